// File: doc/BRIEF.md
# Eight-Point Forward Cosine Transform Pipeline

This block takes eight 8-bit pixel samples in one clock and returns the eight coefficients of their one-dimensional forward discrete cosine transform as signed 10-bit values. The arithmetic follows a fast factorised flow graph. A first add/subtract layer splits the samples into an even half and an odd half. The even half then passes through a second butterfly layer, one root-half scaling node and one plane rotator. The odd half passes through two rotators, a butterfly layer and a final root-half node. Each rotator uses the forward arrangement of signs: the cross terms add into the first output and subtract from the second.

Pixels are unsigned. The block centres them by subtracting 128 before any arithmetic. All constants carry 12 fractional bits. Intermediate results keep their full fractional precision until the last stage. That stage rounds every coefficient to nearest and clamps it to the signed 10-bit range. The pipeline accepts a new vector on every clock. It raises its ready strobe a fixed five clock edges after it accepts a vector. The coefficient bus holds its value between results. Row/column sequencing for a two-dimensional transform is left to the surrounding logic.

Top module: `fdct8_core`

## Requirements
- R1: While reset is high, and on the first edge after it, `cf_rdy` is low and every field of `cf_out` is zero.
- R2: A vector is accepted when `px_vld` is high at a rising edge. Each accepted vector produces exactly one cycle of `cf_rdy`, visible after the fifth rising edge counted from the accepting edge. Vectors on consecutive clocks give results on consecutive clocks, in the same order. `cf_rdy` never rises without an accepted vector.
- R3: Each sample is read as unsigned and offset by -128. A vector with every sample equal to 128 gives all eight coefficients exactly zero.
- R4: When all eight samples equal v, field 0 equals round((v-128)·2·√2) within ±1, and fields 1 to 7 are exactly zero.
- R5: For any input, field k equals round((c_k/2)·Σ_n (x_n-128)·cos((2n+1)kπ/16)) within ±1. Here c_0 = √½ and c_k = 1 for k > 0.
- R6: Sample n sits at `px_in[8n+7:8n]`. Coefficient k sits at `cf_out[10k+9:10k]` as a two's-complement value.
- R7: In any cycle after which no result completes, `cf_out` keeps its previous value.
- R8: When the input is mirror-symmetric (x_n = x_(7-n) for all n), the odd coefficients (fields 1, 3, 5 and 7) are exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| px_vld | input | 1 | Marks `px_in` as a vector to transform |
| px_in | input | 64 | Eight unsigned pixels, sample n at bits 8n+7:8n |
| cf_rdy | output | 1 | One-cycle strobe: `cf_out` carries a new result |
| cf_out | output | 80 | Eight signed coefficients, coefficient k at bits 10k+9:10k |

## Verification
The bench drives uniform vectors at the centre value and at both extremes. These would expose a design that forgets the level shift, or that leaks rounding error into the AC terms, because those terms must come out exactly zero. Mirror-symmetric, ramp, impulse and alternating vectors follow. A wrong sign in a rotator cross term, a swapped odd output, or a misplaced field would put energy in the wrong coefficient, or in odd coefficients that should be zero. A long back-to-back burst of pseudo-random vectors, compared against a floating-point cosine sum, catches lost or reordered results and a latency that is not five edges. An idle gap between results shows whether a design lets the output bus drift when no result completes.

// File: rtl/fdct8_pkg.sv
package fdct8_pkg;

  localparam int PKG_PIX_W  = 8;
  localparam int PKG_COEF_W = 10;
  localparam int FRAC       = 12;
  localparam int ACC_W      = 40;
  localparam int N_PT       = 8;

  // Constants scaled by 2^FRAC; the 1/2 output normalisation is folded
  // into the rotator constants.
  localparam int K_RH  = 2896;  // sqrt(1/2)
  localparam int K_C6H = 784;   // cos(3pi/8)/2
  localparam int K_C2H = 1892;  // cos(pi/8)/2
  localparam int K_C3H = 1703;  // cos(3pi/16)/2
  localparam int K_S3H = 1138;  // sin(3pi/16)/2
  localparam int K_C1H = 2009;  // cos(pi/16)/2
  localparam int K_S1H = 400;   // sin(pi/16)/2

  typedef logic signed [ACC_W-1:0] acc_t;

  // Forward rotator, first leg: both products add.
  function automatic acc_t rot_fwd_a(acc_t u, acc_t v, int ka, int kb);
    return u * acc_t'(ka) + v * acc_t'(kb);
  endfunction

  // Forward rotator, second leg: the cross term subtracts.
  function automatic acc_t rot_fwd_b(acc_t u, acc_t v, int ka, int kb);
    return v * acc_t'(ka) - u * acc_t'(kb);
  endfunction

  // Round to nearest at the given binary point, then clamp to cw signed bits.
  function automatic acc_t round_clamp(acc_t v, int shift, int cw);
    acc_t r;
    acc_t hi;
    acc_t lo;
    r  = (v + (acc_t'(1) <<< (shift - 1))) >>> shift;
    hi = (acc_t'(1) <<< (cw - 1)) - acc_t'(1);
    lo = -hi - acc_t'(1);
    if (r > hi)      r = hi;
    else if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/fdct8_stage1.sv
module fdct8_stage1
  import fdct8_pkg::*;
#(
  parameter int NP = N_PT
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  acc_t x   [NP],
  output acc_t sum [NP/2],
  output acc_t dif [NP/2]
);
  localparam int HALF = NP / 2;

  for (genvar i = 0; i < HALF; i++) begin : g_bfly
    always_ff @(posedge clk) begin
      if (rst) begin
        sum[i] <= '0;
        dif[i] <= '0;
      end else if (en) begin
        sum[i] <= x[i] + x[NP-1-i];
        dif[i] <= x[i] - x[NP-1-i];
      end
    end
  end

endmodule

// File: rtl/fdct8_rot.sv
module fdct8_rot
  import fdct8_pkg::*;
#(
  parameter int KA = K_C6H,
  parameter int KB = K_C2H
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  acc_t u,
  input  acc_t v,
  output acc_t o_a,
  output acc_t o_b
);

  always_ff @(posedge clk) begin
    if (rst) begin
      o_a <= '0;
      o_b <= '0;
    end else if (en) begin
      o_a <= rot_fwd_a(u, v, KA, KB);
      o_b <= rot_fwd_b(u, v, KA, KB);
    end
  end

endmodule

// File: rtl/fdct8_rhalf.sv
module fdct8_rhalf
  import fdct8_pkg::*;
#(
  parameter int KR = K_RH
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  acc_t a,
  input  acc_t b,
  output acc_t s_o,
  output acc_t d_o
);
  acc_t s_c;
  acc_t d_c;

  always_comb begin
    s_c = (a + b) * acc_t'(KR);
    d_c = (a - b) * acc_t'(KR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_o <= '0;
      d_o <= '0;
    end else if (en) begin
      s_o <= s_c;
      d_o <= d_c;
    end
  end

endmodule

// File: rtl/fdct8_core.sv
module fdct8_core
  import fdct8_pkg::*;
#(
  parameter int PIX_W  = PKG_PIX_W,
  parameter int COEF_W = PKG_COEF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    px_vld,
  input  logic [N_PT*PIX_W-1:0]   px_in,
  output logic                    cf_rdy,
  output logic [N_PT*COEF_W-1:0]  cf_out
);
  localparam int HALF   = N_PT / 2;
  localparam int OFFSET = 1 << (PIX_W - 1);
  localparam int SH_OUT = 2 * FRAC;
  localparam int AL_DC  = SH_OUT - (FRAC + 1);
  localparam int AL_ROT = SH_OUT - FRAC;

  // stage valids, brought out for the checker
  logic vld_s1, vld_s2, vld_s3, vld_s4;

  acc_t xs    [N_PT];
  acc_t a_sum [HALF];
  acc_t a_dif [HALF];

  for (genvar n = 0; n < N_PT; n++) begin : g_shift
    assign xs[n] = acc_t'({{(ACC_W-PIX_W){1'b0}}, px_in[n*PIX_W +: PIX_W]}) - acc_t'(OFFSET);
  end

  // stage 1: input butterflies
  fdct8_stage1 #(.NP(N_PT)) u_s1 (
    .clk(clk), .rst(rst), .en(px_vld), .x(xs), .sum(a_sum), .dif(a_dif)
  );

  // stage 2: even butterflies, odd rotators
  acc_t b0, b1, b2, b3;
  acc_t p4, p5, p6, p7;

  always_ff @(posedge clk) begin
    if (rst) begin
      b0 <= '0; b1 <= '0; b2 <= '0; b3 <= '0;
    end else if (vld_s1) begin
      b0 <= a_sum[0] + a_sum[3];
      b3 <= a_sum[0] - a_sum[3];
      b1 <= a_sum[1] + a_sum[2];
      b2 <= a_sum[1] - a_sum[2];
    end
  end

  fdct8_rot #(.KA(K_C3H), .KB(K_S3H)) u_rot_o3 (
    .clk(clk), .rst(rst), .en(vld_s1), .u(a_dif[3]), .v(a_dif[0]), .o_a(p4), .o_b(p7)
  );
  fdct8_rot #(.KA(K_C1H), .KB(K_S1H)) u_rot_o1 (
    .clk(clk), .rst(rst), .en(vld_s1), .u(a_dif[2]), .v(a_dif[1]), .o_a(p5), .o_b(p6)
  );

  // stage 3: even root-half node and rotator, odd butterflies
  acc_t e0, e4, e2, e6;
  acc_t q4, q5, q6, q7;

  fdct8_rhalf #(.KR(K_RH)) u_rh_even (
    .clk(clk), .rst(rst), .en(vld_s2), .a(b0), .b(b1), .s_o(e0), .d_o(e4)
  );
  fdct8_rot #(.KA(K_C6H), .KB(K_C2H)) u_rot_e (
    .clk(clk), .rst(rst), .en(vld_s2), .u(b2), .v(b3), .o_a(e2), .o_b(e6)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q4 <= '0; q5 <= '0; q6 <= '0; q7 <= '0;
    end else if (vld_s2) begin
      q4 <= p4 + p6;
      q6 <= p4 - p6;
      q7 <= p7 + p5;
      q5 <= p7 - p5;
    end
  end

  // stage 4: odd root-half node, align all terms to SH_OUT fraction bits
  acc_t o1, o7;
  acc_t al0, al2, al3, al4, al5, al6;

  fdct8_rhalf #(.KR(K_RH)) u_rh_odd (
    .clk(clk), .rst(rst), .en(vld_s3), .a(q7), .b(q4), .s_o(o1), .d_o(o7)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      al0 <= '0; al2 <= '0; al3 <= '0; al4 <= '0; al5 <= '0; al6 <= '0;
    end else if (vld_s3) begin
      al0 <= e0 <<< AL_DC;
      al4 <= e4 <<< AL_DC;
      al2 <= e2 <<< AL_ROT;
      al6 <= e6 <<< AL_ROT;
      al3 <= q5 <<< AL_ROT;
      al5 <= q6 <<< AL_ROT;
    end
  end

  acc_t fin [N_PT];
  always_comb begin
    fin[0] = al0; fin[1] = o1;  fin[2] = al2; fin[3] = al3;
    fin[4] = al4; fin[5] = al5; fin[6] = al6; fin[7] = o7;
  end

  // stage 5: round, clamp, present
  for (genvar k = 0; k < N_PT; k++) begin : g_out
    acc_t rc;
    assign rc = round_clamp(fin[k], SH_OUT, COEF_W);
    always_ff @(posedge clk) begin
      if (rst)         cf_out[k*COEF_W +: COEF_W] <= '0;
      else if (vld_s4) cf_out[k*COEF_W +: COEF_W] <= rc[COEF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_s1 <= 1'b0; vld_s2 <= 1'b0; vld_s3 <= 1'b0; vld_s4 <= 1'b0;
      cf_rdy <= 1'b0;
    end else begin
      vld_s1 <= px_vld;
      vld_s2 <= vld_s1;
      vld_s3 <= vld_s2;
      vld_s4 <= vld_s3;
      cf_rdy <= vld_s4;
    end
  end

endmodule

// File: rtl/fdct8_chk.sv
module fdct8_chk
  import fdct8_pkg::*;
#(
  parameter int BUS_W = N_PT * PKG_COEF_W
) (
  input logic             clk,
  input logic             rst,
  input logic             px_vld,
  input logic             vld_s1,
  input logic             vld_s2,
  input logic             vld_s3,
  input logic             vld_s4,
  input logic             cf_rdy,
  input logic [BUS_W-1:0] cf_out
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!cf_rdy && cf_out == '0));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    px_vld |=> vld_s1);

  // R2
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    !px_vld |=> !vld_s1);

  // R2
  mid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_s1 |=> vld_s2) and (vld_s2 |=> vld_s3) and (vld_s3 |=> vld_s4));

  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vld_s4 |=> cf_rdy);

  // R2
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_s4 |=> !cf_rdy);

  // R7
  hold_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_s4 |=> $stable(cf_out));

endmodule

bind fdct8_core fdct8_chk u_chk (
  .clk(clk), .rst(rst), .px_vld(px_vld),
  .vld_s1(vld_s1), .vld_s2(vld_s2), .vld_s3(vld_s3), .vld_s4(vld_s4),
  .cf_rdy(cf_rdy), .cf_out(cf_out)
);

// File: tb/sim_fdct8_core.sv
`timescale 1ns/1ps
module sim_fdct8_core;
  localparam int PW = 8;
  localparam int CW = 10;
  localparam int NP = 8;
  localparam int DEPTH = 5;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst;
  logic px_vld;
  logic [NP*PW-1:0] px_in;
  logic cf_rdy;
  logic [NP*CW-1:0] cf_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [NP*CW-1:0] last_out = '0;

  int    exp_q [$];
  bit    exa_q [$];
  int    tin_q [$];
  string tag_q [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fdct8_core u0 (
    .clk(clk), .rst(rst), .px_vld(px_vld), .px_in(px_in),
    .cf_rdy(cf_rdy), .cf_out(cf_out)
  );

  function automatic int ref_coef(int xs[NP], int k);
    real acc = 0.0;
    for (int n = 0; n < NP; n++)
      acc += real'(xs[n] - 128) * $cos(real'((2*n+1)*k) * PI / 16.0);
    acc = (k == 0) ? acc * 0.5 * 0.70710678118 : acc * 0.5;
    return (acc >= 0.0) ? $rtoi(acc + 0.5) : -$rtoi(-acc + 0.5);
  endfunction

  function automatic int field(logic [NP*CW-1:0] bus, int k);
    logic signed [CW-1:0] f;
    f = bus[k*CW +: CW];
    return int'(f);
  endfunction

  task automatic tally(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic send(int xs[NP], bit [NP-1:0] exact, string tag);
    for (int n = 0; n < NP; n++) px_in[n*PW +: PW] = xs[n][PW-1:0];
    px_vld = 1'b1;
    for (int k = 0; k < NP; k++) begin
      exp_q.push_back(ref_coef(xs, k));
      exa_q.push_back(exact[k]);
    end
    tin_q.push_back(cyc);
    tag_q.push_back(tag);
    @(negedge clk);
    px_vld = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && tin_q.size() > 0; i++) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && cf_rdy) begin
      if (tin_q.size() == 0) begin
        tally(1'b0, "R2", "unexpected ready", 1, 0);
      end else begin
        int t0;
        string tg;
        t0 = tin_q.pop_front();
        tg = tag_q.pop_front();
        tally((cyc - t0) == DEPTH, "R2", "latency", cyc - t0, DEPTH);
        for (int k = 0; k < NP; k++) begin
          int e;
          bit x;
          int a;
          e = exp_q.pop_front();
          x = exa_q.pop_front();
          a = field(cf_out, k);
          if (x) tally(a == e, tg, $sformatf("coef%0d exact", k), a, e);
          else   tally((a - e) <= 1 && (e - a) <= 1, tg, $sformatf("coef%0d", k), a, e);
        end
        last_out = cf_out;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v[NP];
    int s;
    rst = 1'b1;
    px_vld = 1'b0;
    px_in = '0;
    repeat (3) @(negedge clk);
    tally(cf_rdy == 1'b0, "R1", "ready in reset", int'(cf_rdy), 0);
    tally(cf_out == '0, "R1", "bus in reset", field(cf_out, 0), 0);
    rst = 1'b0;
    @(negedge clk);
    tally(cf_rdy == 1'b0 && cf_out == '0, "R1", "after reset", int'(cf_rdy), 0);

    // R3: centre value gives exactly zero everywhere
    send('{128,128,128,128,128,128,128,128}, 8'hFF, "R3");
    // R4: uniform vectors, only DC nonzero
    send('{200,200,200,200,200,200,200,200}, 8'hFE, "R4");
    send('{0,0,0,0,0,0,0,0}, 8'hFE, "R4");
    send('{255,255,255,255,255,255,255,255}, 8'hFE, "R4");
    // R5/R6: ramp and impulse locate each field
    send('{20,50,80,110,140,170,200,230}, 8'h00, "R6");
    send('{255,128,128,128,128,128,128,128}, 8'h00, "R6");
    // R8: mirror symmetric input, odd terms exactly zero
    send('{10,60,200,90,90,200,60,10}, 8'hAA, "R8");
    send('{0,255,0,255,0,255,0,255}, 8'h00, "R5");
    drain();

    // R7: bus holds through an idle gap
    repeat (6) @(negedge clk);
    tally(cf_out == last_out, "R7", "hold after gap", field(cf_out, 0), field(last_out, 0));
    tally(cf_rdy == 1'b0, "R7", "ready idle", int'(cf_rdy), 0);

    // R2/R5: back-to-back pseudo-random burst
    s = 32'h1234_5677;
    for (int b = 0; b < 24; b++) begin
      for (int n = 0; n < NP; n++) begin
        s = s ^ (s << 13);
        s = s ^ (s >>> 17);
        s = s ^ (s << 5);
        v[n] = s & 255;
      end
      send(v, 8'h00, "R5");
    end
    drain();
    repeat (3) @(negedge clk);
    tally(tin_q.size() == 0, "R2", "all results seen", tin_q.size(), 0);
    tally(cf_out == last_out, "R7", "hold after burst", field(cf_out, 1), field(last_out, 1));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule